// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address. It reads two page table entries from memory, and each read depends on the result of the one before it. A requester gives a virtual address, a flag that marks the access as a store, and the frame number of the root table. The walker splits the address into two table indices and a page offset. It reads the root-table entry, then the entry in the second table that the root entry points to. It returns the physical address, or a fault code when the walk cannot finish.

Pages are 4 KB and aligned. The 12 offset bits pass through unchanged, and the 20-bit virtual page number is replaced by the frame number held in the leaf entry. Each entry is 32 bits wide. Bit 0 is the valid bit, bit 1 allows writes, bit 2 is the dirty flag, and bits 31:12 hold a frame number. Memory reads go out on a valid/ready request channel and come back as a one-cycle data strobe. Only one walk is in flight at a time. A walk stops at the first fault it finds.

Top module: `pt_walker`

## Requirements
- R1: After reset, and whenever the walker is idle, `req_ready` is 1 while `mem_req_valid` and `rsp_valid` are 0.
- R2: The first memory read goes to the address {`tbl_frame`, va[31:22], 2'b00}.
- R3: The second read goes to the address {root entry[31:12], va[21:12], 2'b00}. It is issued only after the root entry has returned and passed its checks.
- R4: When the walk succeeds, `rsp_fault` is 0, `rsp_cause` is 0 and `rsp_paddr` is {leaf entry[31:12], va[11:0]}. For example, 0xFC51908B through a leaf frame of 0x00152 gives 0x0015208B.
- R5: If bit 0 of the root entry is 0, the walk ends with `rsp_fault`=1, `rsp_cause`=1 and `rsp_paddr`=0, and no second read is issued.
- R6: If bit 0 of the leaf entry is 0, the walk ends with `rsp_fault`=1, `rsp_cause`=2 and `rsp_paddr`=0.
- R7: A store through a valid leaf entry whose bit 1 is 0 ends with `rsp_fault`=1, `rsp_cause`=3 and `rsp_paddr`=0. A load through the same entry succeeds, and so does a store when bit 1 is 1.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and `mem_req_addr` holds its value.
- R9: `req_ready` drops in the cycle after a request is accepted. It stays 0 through the whole walk, including the cycle in which `rsp_valid` is 1. `rsp_valid` lasts exactly one cycle, and a waiting request is accepted on the next cycle.
- R10: Entry bits 11:2 have no effect on the result. This includes the dirty bit, and it includes bit 1 of the root entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A translation request is present |
| req_ready | output | 1 | The walker is idle and takes the request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 when the access is a store |
| tbl_frame | input | 20 | Frame number of the root table |
| mem_req_valid | output | 1 | An entry read is requested |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | The entry data is valid this cycle |
| mem_rsp_data | input | 32 | Entry returned by memory |
| rsp_valid | output | 1 | One-cycle strobe that marks the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | The walk faulted |
| rsp_cause | output | 2 | 0 none, 1 root invalid, 2 leaf invalid, 3 write denied |

## Verification
Two events can fall in the same cycle: the result of one walk is delivered, and the next request is already waiting at the input. The bench keeps `req_valid` high with a second address during the whole first walk. It checks that `req_ready` is 0 in every wait cycle and in the strobe cycle, that it returns to 1 one cycle later, and that both results come back intact. A second case stalls the read channel and delays the data, so that the entry checks and the hold on the request are tested under back-pressure.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    WK_IDLE, WK_L1_REQ, WK_L1_WAIT, WK_L2_REQ, WK_L2_WAIT, WK_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE       = 2'd0,
    FLT_L1_INVALID = 2'd1,
    FLT_L2_INVALID = 2'd2,
    FLT_NO_WRITE   = 2'd3
  } fault_cause_e;

  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_WRITE_BIT = 1;
  localparam int ENT_DIRTY_BIT = 2;
endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [PA_W-OFF_W-1:0] table_frame,
  input  logic [IDX_W-1:0]      index,
  output logic [PA_W-1:0]       entry_addr
);
  // each entry occupies four bytes
  localparam int ENT_SHIFT = 2;

  always_comb begin
    entry_addr = {table_frame, OFF_W'({index, {ENT_SHIFT{1'b0}}})};
  end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_leaf,
  input  logic             is_store,
  output logic             fault,
  output fault_cause_e     cause
);
  always_comb begin
    fault = 1'b0;
    cause = FLT_NONE;
    if (!entry[ENT_VALID_BIT]) begin
      fault = 1'b1;
      cause = is_leaf ? FLT_L2_INVALID : FLT_L1_INVALID;
    end else if (is_leaf && is_store && !entry[ENT_WRITE_BIT]) begin
      fault = 1'b1;
      cause = FLT_NO_WRITE;
    end
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        ent_fault,
  output walk_state_e state,
  output logic        idle,
  output logic        issue,
  output logic        sel_leaf,
  output logic        chk_leaf,
  output logic        load_next,
  output logic        load_result,
  output logic        done
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WK_IDLE:    if (start)         state_d = WK_L1_REQ;
      WK_L1_REQ:  if (mem_req_ready) state_d = WK_L1_WAIT;
      WK_L1_WAIT: if (mem_rsp_valid) state_d = ent_fault ? WK_DONE : WK_L2_REQ;
      WK_L2_REQ:  if (mem_req_ready) state_d = WK_L2_WAIT;
      WK_L2_WAIT: if (mem_rsp_valid) state_d = WK_DONE;
      WK_DONE:                       state_d = WK_IDLE;
      default:                       state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WK_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state       = state_q;
    idle        = (state_q == WK_IDLE);
    issue       = (state_q == WK_L1_REQ) || (state_q == WK_L2_REQ);
    sel_leaf    = (state_q == WK_L2_REQ);
    chk_leaf    = (state_q == WK_L2_WAIT);
    load_next   = (state_q == WK_L1_WAIT) && mem_rsp_valid && !ent_fault;
    load_result = mem_rsp_valid &&
                  (((state_q == WK_L1_WAIT) && ent_fault) || (state_q == WK_L2_WAIT));
    done        = (state_q == WK_DONE);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [L1_W+L2_W+OFF_W-1:0]    req_vaddr,
  input  logic                          req_store,
  input  logic [L1_W+L2_W-1:0]          tbl_frame,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [L1_W+L2_W+OFF_W-1:0]    mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [L1_W+L2_W+OFF_W-1:0]    mem_rsp_data,
  output logic                          rsp_valid,
  output logic [L1_W+L2_W+OFF_W-1:0]    rsp_paddr,
  output logic                          rsp_fault,
  output logic [1:0]                    rsp_cause
);
  localparam int VA_W    = L1_W + L2_W + OFF_W;
  localparam int PA_W    = VA_W;
  localparam int PTE_W   = PA_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int IDX_MAX = (L1_W > L2_W) ? L1_W : L2_W;
  localparam int LEVELS  = 2;

  logic rst_n_int;
  pt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  walk_state_e  state;
  logic         idle, issue, sel_leaf, chk_leaf, load_next, load_result, done;
  logic         ent_fault;
  fault_cause_e ent_cause;
  logic         start;

  logic [VA_W-1:0]    va_q;
  logic               store_q;
  logic [FRAME_W-1:0] root_frame_q, leaf_tbl_q;
  logic [PA_W-1:0]    paddr_q, paddr_d;
  logic               fault_q;
  fault_cause_e       cause_q;

  assign start = req_valid && idle;

  pt_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .start(start),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .ent_fault(ent_fault), .state(state), .idle(idle), .issue(issue),
    .sel_leaf(sel_leaf), .chk_leaf(chk_leaf), .load_next(load_next),
    .load_result(load_result), .done(done)
  );

  pt_entry_check #(.PTE_W(PTE_W)) u_chk_ent (
    .entry(mem_rsp_data), .is_leaf(chk_leaf), .is_store(store_q),
    .fault(ent_fault), .cause(ent_cause)
  );

  // per-level entry address generation
  logic [IDX_MAX-1:0] lvl_idx   [LEVELS];
  logic [FRAME_W-1:0] lvl_frame [LEVELS];
  logic [PA_W-1:0]    lvl_addr  [LEVELS];

  assign lvl_idx[0]   = IDX_MAX'(va_q[VA_W-1 -: L1_W]);
  assign lvl_idx[1]   = IDX_MAX'(va_q[OFF_W+L2_W-1 -: L2_W]);
  assign lvl_frame[0] = root_frame_q;
  assign lvl_frame[1] = leaf_tbl_q;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pt_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_MAX)) u_addr (
      .table_frame(lvl_frame[g]), .index(lvl_idx[g]), .entry_addr(lvl_addr[g])
    );
  end

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      va_q         <= '0;
      store_q      <= 1'b0;
      root_frame_q <= '0;
    end else if (start) begin
      va_q         <= req_vaddr;
      store_q      <= req_store;
      root_frame_q <= tbl_frame;
    end
  end

  // second-level table frame from the root entry
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)     leaf_tbl_q <= '0;
    else if (load_next) leaf_tbl_q <= mem_rsp_data[PTE_W-1 -: FRAME_W];
  end

  always_comb begin
    if (ent_fault) paddr_d = '0;
    else           paddr_d = {mem_rsp_data[PTE_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
      cause_q <= FLT_NONE;
    end else if (load_result) begin
      paddr_q <= paddr_d;
      fault_q <= ent_fault;
      cause_q <= ent_cause;
    end
  end

  // metadata bits that never steer the walk
  logic pte_unused_meta;
  assign pte_unused_meta = ^{mem_rsp_data[OFF_W-1:ENT_DIRTY_BIT], state};

  assign req_ready     = idle;
  assign mem_req_valid = issue;
  assign mem_req_addr  = sel_leaf ? lvl_addr[1] : lvl_addr[0];
  assign rsp_valid     = done;
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_cause     = cause_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [AW-1:0] rsp_paddr,
  input logic [1:0]    rsp_cause
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  p_success_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));

  p_fault_noaddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_cause != 2'd0));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_busy_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind pt_walker pt_walker_chk #(.AW(L1_W+L2_W+OFF_W)) u_walker_chk (
  .clk(clk), .rst_n(rst_n_int), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_store;
  logic [31:0] req_vaddr;
  logic [19:0] tbl_frame;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;

  always #10 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .tbl_frame(tbl_frame),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // memory model storage
  logic [31:0] m_addr [16];
  logic [31:0] m_data [16];
  int          m_cnt;
  logic [31:0] alog [8];
  int          n_addr;
  int          stall_cfg, lat_cfg, stall_left, hold_err;

  // captured result
  logic [31:0] got_pa;
  logic        got_flt;
  logic [1:0]  got_cause;

  function automatic logic [31:0] l1_addr(logic [19:0] f, logic [31:0] va);
    return {f, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] l2_addr(logic [31:0] e, logic [31:0] va);
    return {e[31:12], va[21:12], 2'b00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mem_put(logic [31:0] a, logic [31:0] d);
    m_addr[m_cnt] = a; m_data[m_cnt] = d; m_cnt++;
  endtask

  function automatic logic [31:0] mem_get(logic [31:0] a);
    for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) return m_data[i];
    return 32'h0;
  endfunction

  task automatic setup(int stall, int lat);
    m_cnt = 0; n_addr = 0; hold_err = 0;
    stall_cfg = stall; lat_cfg = lat; stall_left = stall;
  endtask

  // memory responder, driven on falling edges
  initial begin
    logic        hs_pend, pend, pw_valid;
    logic [31:0] hs_addr, pend_addr, pw_addr;
    int          cnt;
    hs_pend = 0; pend = 0; pw_valid = 0; cnt = 0;
    hs_addr = '0; pend_addr = '0; pw_addr = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (hs_pend) begin
        pend = 1; cnt = lat_cfg; pend_addr = hs_addr; hs_pend = 0;
        if (n_addr < 8) alog[n_addr] = hs_addr;
        n_addr++;
        stall_left = stall_cfg;
      end
      mem_rsp_valid = 0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = mem_get(pend_addr); pend = 0;
        end else cnt--;
      end
      if (pw_valid && (!mem_req_valid || mem_req_addr != pw_addr)) hold_err++;
      if (mem_req_valid && stall_left > 0) begin
        mem_req_ready = 0; stall_left--;
      end else mem_req_ready = (stall_left == 0);
      hs_pend  = mem_req_valid && mem_req_ready;
      hs_addr  = mem_req_addr;
      pw_valid = mem_req_valid && !mem_req_ready;
      pw_addr  = mem_req_addr;
    end
  end

  task automatic send(logic [31:0] va, logic st, logic [19:0] f);
    req_vaddr = va; req_store = st; tbl_frame = f; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_rsp();
    for (int i = 0; i < 200; i++) begin
      if (rsp_valid) begin
        got_pa = rsp_paddr; got_flt = rsp_fault; got_cause = rsp_cause;
        return;
      end
      @(negedge clk);
    end
    got_pa = 'x; got_flt = 1'bx; got_cause = 'x;
  endtask

  localparam logic [19:0] ROOT = 20'h00040;
  localparam logic [31:0] VA_EX = 32'hFC51908B;

  task automatic t_reset();
    check("R1 req_ready", {31'b0, req_ready}, 32'd1);
    check("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_example();
    setup(0, 0);
    mem_put(l1_addr(ROOT, VA_EX), 32'h00050001);
    mem_put(l2_addr(32'h00050001, VA_EX), 32'h00152003);
    send(VA_EX, 0, ROOT); wait_rsp();
    check("R4 example paddr", got_pa, 32'h0015208B);
    check("R4 example fault", {30'b0, got_flt, 1'b0} | got_cause, 32'd0);
    check("R2 first read addr", alog[0], 32'h00040FC4);
    check("R3 second read addr", alog[1], 32'h00050464);
    check("R3 read count", n_addr, 2);
    @(negedge clk);
    check("R1 idle after walk", {30'b0, req_ready, mem_req_valid}, 32'd2);
  endtask

  task automatic t_stall();
    logic [31:0] va = 32'h1234_5ABC;
    setup(3, 4);
    mem_put(l1_addr(ROOT, va), 32'h00077001);
    mem_put(l2_addr(32'h00077001, va), 32'hABCDE007);
    send(va, 1, ROOT); wait_rsp();
    check("R4 stalled paddr", got_pa, 32'hABCDEABC);
    check("R2 stalled first addr", alog[0], l1_addr(ROOT, va));
    check("R3 stalled second addr", alog[1], l2_addr(32'h00077001, va));
    check("R8 request held under stall", hold_err, 0);
    setup(0, 0);
  endtask

  task automatic t_l1_invalid();
    logic [31:0] va = 32'h0040_1000;
    setup(0, 1);
    mem_put(l1_addr(ROOT, va), 32'h00050006);
    send(va, 0, ROOT); wait_rsp();
    check("R5 fault flag", {31'b0, got_flt}, 32'd1);
    check("R5 cause", {30'b0, got_cause}, 32'd1);
    check("R5 paddr zero", got_pa, 32'd0);
    check("R5 no second read", n_addr, 1);
  endtask

  task automatic t_l2_invalid();
    logic [31:0] va = 32'h8000_3123;
    setup(0, 0);
    mem_put(l1_addr(ROOT, va), 32'h00060001);
    mem_put(l2_addr(32'h00060001, va), 32'h00999006);
    send(va, 0, ROOT); wait_rsp();
    check("R6 fault flag", {31'b0, got_flt}, 32'd1);
    check("R6 cause", {30'b0, got_cause}, 32'd2);
    check("R6 paddr zero", got_pa, 32'd0);
  endtask

  task automatic t_write_perm();
    logic [31:0] va = 32'h0C00_2FFF;
    setup(1, 0);
    mem_put(l1_addr(ROOT, va), 32'h00061001);
    mem_put(l2_addr(32'h00061001, va), 32'h00333001);
    send(va, 1, ROOT); wait_rsp();
    check("R7 store denied cause", {30'b0, got_cause}, 32'd3);
    check("R7 store denied paddr", got_pa, 32'd0);
    check("R7 store denied flag", {31'b0, got_flt}, 32'd1);
    @(negedge clk);
    send(va, 0, ROOT); wait_rsp();
    check("R7 load on read-only page", got_pa, 32'h00333FFF);
    @(negedge clk);
    m_cnt = 0;
    mem_put(l1_addr(ROOT, va), 32'h00061001);
    mem_put(l2_addr(32'h00061001, va), 32'h00333003);
    send(va, 1, ROOT); wait_rsp();
    check("R7 store on writable page", {got_flt, got_pa[30:0]}, 32'h00333FFF);
  endtask

  task automatic t_meta();
    logic [31:0] va = 32'h4567_8001;
    setup(0, 2);
    mem_put(l1_addr(ROOT, va), 32'h00062FFD);
    mem_put(l2_addr(32'h00062000, va), 32'h00444FFF);
    send(va, 1, ROOT); wait_rsp();
    check("R10 metadata ignored paddr", got_pa, 32'h00444001);
    check("R10 metadata ignored cause", {29'b0, got_flt, got_cause}, 32'd0);
    check("R10 second addr uses frame only", alog[1], l2_addr(32'h00062000, va));
  endtask

  task automatic t_busy();
    logic [31:0] va_a = 32'h0100_0010, va_b = 32'h0200_0020;
    int busy_err = 0;
    setup(2, 1);
    mem_put(l1_addr(ROOT, va_a), 32'h00070001);
    mem_put(l2_addr(32'h00070001, va_a), 32'h00AAA001);
    mem_put(l1_addr(ROOT, va_b), 32'h00071001);
    mem_put(l2_addr(32'h00071001, va_b), 32'h00BBB001);
    req_vaddr = va_a; req_store = 0; tbl_frame = ROOT; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_vaddr = va_b;
    for (int i = 0; i < 200 && !rsp_valid; i++) begin
      if (req_ready) busy_err++;
      @(negedge clk);
    end
    check("R9 busy during walk", busy_err, 0);
    check("R9 not ready at strobe", {31'b0, req_ready}, 32'd0);
    check("R9 first result", rsp_paddr, 32'h00AAA010);
    @(negedge clk);
    check("R9 strobe one cycle", {31'b0, rsp_valid}, 32'd0);
    check("R9 ready after strobe", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 0;
    wait_rsp();
    check("R9 queued second result", got_pa, 32'h00BBB020);
  endtask

  initial begin
    req_valid = 0; req_store = 0; req_vaddr = '0; tbl_frame = '0;
    stall_cfg = 0; lat_cfg = 0; stall_left = 0; m_cnt = 0; n_addr = 0; hold_err = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_example();    @(negedge clk);
    t_stall();      @(negedge clk);
    t_l1_invalid(); @(negedge clk);
    t_l2_invalid(); @(negedge clk);
    t_write_perm(); @(negedge clk);
    t_meta();       @(negedge clk);
    t_busy();       @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule